// File: doc/BRIEF.md
# Fragmented Mailbox Message Receiver

This block pulls a message out of a word-wide slot mailbox, where the sender has split it into one or more fragments. Each fragment starts with a 32-bit header word. The header carries a byte length in bits 24:16 and a final-fragment flag in bit 31. The payload words follow the header, and the lowest-addressed byte sits in the least significant byte lane. The receiver unpacks the payload into a byte-wide write port. Writes go to consecutive addresses starting at zero, across fragment boundaries, up to a capacity that is latched when the receive starts.

A receive begins with a one-cycle `start` pulse. The block waits for the peer to report ready, and it gives the peer several timeout windows to do so. It then walks through the fragments. It stops successfully on a fragment flagged final. It stops with an error on an oversize fragment, on the peer dropping ready during a fragment, on running out of capacity before the final fragment, or on the peer never becoming ready. If a non-final fragment leaves the mailbox empty, the block pulses a doorbell to ask the sender for more data.

Top module: `msg_reassembler`

## Requirements
- R1: After reset, `done`, `error`, `slot_pop`, `wr_en` and `doorbell` are low and `rx_len` is zero.
- R2: A header is popped only when `fill_cnt` is non-zero. Its length comes from bits 24:16 and its final flag from bit 31. Bits 30:25 and 15:0 are ignored.
- R3: A fragment whose length exceeds the remaining capacity (latched capacity minus bytes already written) ends the receive with `error`, and none of its bytes are written.
- R4: No payload slot is popped until `fill_cnt` is at least ceil(length/4).
- R5: Each whole payload word is written byte by byte, from least significant byte to most significant, to addresses that rise by one from 0 and continue across fragments.
- R6: When length mod 4 is non-zero, one extra slot is popped and only its low (length mod 4) bytes are written.
- R7: If `peer_ready` is low once a fragment's whole words have been consumed, the receive ends with `error` and no tail slot is popped.
- R8: After a non-final fragment, `doorbell` pulses for exactly one cycle if `fill_cnt` is zero, and stays low otherwise.
- R9: A fragment flagged final ends the receive with `done` high, `error` low and `rx_len` equal to the total bytes written. `done` and `error` hold until the next `start`, and `error` never appears without `done`.
- R10: A zero-length fragment is accepted. It writes nothing, and it completes the message if it is flagged final.
- R11: If capacity is used up exactly by a non-final fragment, the receive ends with `error` and no doorbell.
- R12: While waiting for `peer_ready`, the block allows up to RETRIES windows of TIMEOUT cycles each. If all of them expire, it ends with `error`. If ready arrives inside any window, the receive proceeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a receive while idle |
| capacity | input | CAP_W | Output buffer capacity in bytes, latched on start |
| fill_cnt | input | CNT_W | Number of filled mailbox slots |
| slot_data | input | 32 | Word at the head of the mailbox |
| peer_ready | input | 1 | Peer reports it is ready |
| slot_pop | output | 1 | Consumes the head mailbox slot on this clock edge |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | CAP_W | Byte write address |
| wr_data | output | 8 | Byte write data |
| doorbell | output | 1 | One-cycle request for more data |
| rx_len | output | CAP_W | Bytes received so far / total on completion |
| done | output | 1 | Receive finished (held until next start) |
| error | output | 1 | Receive finished with failure (held until next start) |

## Verification
The hardest case to reach is the peer dropping ready in the middle of a fragment. The check only happens in the single cycle after the last whole word has been unpacked, so the bench watches the byte port and pulls `peer_ready` low on the first byte write of an eight-byte fragment. The doorbell path needs a similar trick: the bench loads only the first non-final fragment, waits for the doorbell pulse and only then feeds the final one. A second run preloads both fragments to show that no pulse appears. The retry window is reached by holding ready low and counting the cycles until `done`.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

    localparam int HDR_LEN_LSB   = 16;
    localparam int HDR_LEN_W     = 9;
    localparam int HDR_FINAL_BIT = 31;
    localparam int WCNT_W        = HDR_LEN_W - 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_RDY,
        S_HDR,
        S_PAY,
        S_WORDS,
        S_BYTES,
        S_RDY_CHK,
        S_FRAG_END
    } rx_state_e;

    typedef struct packed {
        logic [WCNT_W-1:0] words;
        logic [1:0]        tail;
        logic              final_frag;
    } frag_info_t;

    function automatic logic [HDR_LEN_W-1:0] hdr_len(input logic [31:0] w);
        return w[HDR_LEN_LSB +: HDR_LEN_W];
    endfunction

    function automatic frag_info_t hdr_decode(input logic [31:0] w);
        frag_info_t f;
        logic [HDR_LEN_W-1:0] l;
        l            = hdr_len(w);
        f.words      = l[HDR_LEN_W-1:2];
        f.tail       = l[1:0];
        f.final_frag = w[HDR_FINAL_BIT];
        return f;
    endfunction

    function automatic logic [WCNT_W:0] slots_needed(input frag_info_t f);
        return {1'b0, f.words} + {{WCNT_W{1'b0}}, (f.tail != 2'd0)};
    endfunction

endpackage

// File: rtl/rxm_ready_waiter.sv
module rxm_ready_waiter #(
    parameter int TIMEOUT = 1000,
    parameter int RETRIES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic gave_up
);
    localparam int TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam int RW = $clog2(RETRIES + 1);

    logic [TW-1:0] timer_q;
    logic [RW-1:0] tries_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            timer_q <= '0;
            tries_q <= '0;
        end else if (run && !gave_up) begin
            if (timer_q == TW'(TIMEOUT - 1)) begin
                timer_q <= '0;
                tries_q <= tries_q + 1'b1;
            end else begin
                timer_q <= timer_q + 1'b1;
            end
        end
    end

    assign gave_up = (tries_q == RW'(RETRIES));
endmodule

// File: rtl/rxm_unpacker.sv
module rxm_unpacker (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] word,
    input  logic [2:0]  nbytes,
    output logic        valid,
    output logic        last,
    output logic [7:0]  byte_out
);
    logic [31:0] sh_q;
    logic [2:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= word;
            cnt_q <= nbytes;
        end else if (cnt_q != 3'd0) begin
            sh_q  <= {8'h00, sh_q[31:8]};
            cnt_q <= cnt_q - 3'd1;
        end
    end

    assign valid    = (cnt_q != 3'd0);
    assign last     = (cnt_q == 3'd1);
    assign byte_out = sh_q[7:0];
endmodule

// File: rtl/msg_reassembler.sv
module msg_reassembler
    import rxm_pkg::*;
#(
    parameter int CAP_W   = 10,
    parameter int CNT_W   = 8,
    parameter int TIMEOUT = 1000,
    parameter int RETRIES = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CAP_W-1:0] capacity,
    input  logic [CNT_W-1:0] fill_cnt,
    input  logic [31:0]      slot_data,
    input  logic             peer_ready,
    output logic             slot_pop,
    output logic             wr_en,
    output logic [CAP_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             doorbell,
    output logic [CAP_W-1:0] rx_len,
    output logic             done,
    output logic             error
);
    rx_state_e         st_q, st_nxt;
    frag_info_t        frag_q, hdr_now;
    logic [CAP_W-1:0]  cap_q, len_q, remaining;
    logic              tail_ph_q, done_q, err_q;
    logic              fin_ok, fin_err, unp_load, unp_valid, unp_last, gave_up;
    logic [2:0]        unp_n;
    logic [7:0]        unp_byte;

    assign hdr_now   = hdr_decode(slot_data);
    assign remaining = cap_q - len_q;

    rxm_ready_waiter #(.TIMEOUT(TIMEOUT), .RETRIES(RETRIES)) u_wait (
        .clk(clk), .rst(rst),
        .clear(st_q == S_IDLE),
        .run(st_q == S_WAIT_RDY && !peer_ready),
        .gave_up(gave_up)
    );

    rxm_unpacker u_unp (
        .clk(clk), .rst(rst),
        .load(unp_load), .word(slot_data), .nbytes(unp_n),
        .valid(unp_valid), .last(unp_last), .byte_out(unp_byte)
    );

    always_comb begin
        st_nxt   = st_q;
        slot_pop = 1'b0;
        unp_load = 1'b0;
        unp_n    = 3'd4;
        doorbell = 1'b0;
        fin_ok   = 1'b0;
        fin_err  = 1'b0;
        unique case (st_q)
            S_IDLE:     if (start) st_nxt = S_WAIT_RDY;
            S_WAIT_RDY: begin
                if (gave_up)         fin_err = 1'b1;
                else if (peer_ready) st_nxt  = S_HDR;
            end
            S_HDR: begin
                if (fill_cnt != '0) begin
                    slot_pop = 1'b1;
                    if (CAP_W'(hdr_len(slot_data)) > remaining) fin_err = 1'b1;
                    else                                         st_nxt  = S_PAY;
                end
            end
            S_PAY: begin
                if (fill_cnt >= CNT_W'(slots_needed(frag_q))) st_nxt = S_WORDS;
            end
            S_WORDS: begin
                if (frag_q.words != '0) begin
                    slot_pop = 1'b1;
                    unp_load = 1'b1;
                    st_nxt   = S_BYTES;
                end else begin
                    st_nxt = S_RDY_CHK;
                end
            end
            S_BYTES: begin
                if (unp_last) st_nxt = tail_ph_q ? S_FRAG_END : S_WORDS;
            end
            S_RDY_CHK: begin
                if (!peer_ready) begin
                    fin_err = 1'b1;
                end else if (frag_q.tail != 2'd0) begin
                    slot_pop = 1'b1;
                    unp_load = 1'b1;
                    unp_n    = {1'b0, frag_q.tail};
                    st_nxt   = S_BYTES;
                end else begin
                    st_nxt = S_FRAG_END;
                end
            end
            S_FRAG_END: begin
                if (frag_q.final_frag)    fin_ok  = 1'b1;
                else if (remaining == '0) fin_err = 1'b1;
                else begin
                    doorbell = (fill_cnt == '0);
                    st_nxt   = S_HDR;
                end
            end
            default: st_nxt = S_IDLE;
        endcase
        if (fin_ok || fin_err) st_nxt = S_IDLE;
    end

    assign wr_en   = (st_q == S_BYTES) && unp_valid;
    assign wr_addr = len_q;
    assign wr_data = unp_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            frag_q    <= '0;
            cap_q     <= '0;
            len_q     <= '0;
            tail_ph_q <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            st_q <= st_nxt;
            if (st_q == S_IDLE && start) begin
                cap_q  <= capacity;
                len_q  <= '0;
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end
            if (wr_en) len_q <= len_q + 1'b1;
            if (st_q == S_HDR && slot_pop) begin
                frag_q    <= hdr_now;
                tail_ph_q <= 1'b0;
            end
            if (st_q == S_WORDS && slot_pop) frag_q.words <= frag_q.words - 1'b1;
            if (st_q == S_RDY_CHK && slot_pop) tail_ph_q <= 1'b1;
            if (fin_ok)  done_q <= 1'b1;
            if (fin_err) begin
                done_q <= 1'b1;
                err_q  <= 1'b1;
            end
        end
    end

    assign rx_len = len_q;
    assign done   = done_q;
    assign error  = err_q;
endmodule

// File: rtl/rxm_checker.sv
module rxm_checker #(
    parameter int CAP_W = 10,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             slot_pop,
    input logic [CNT_W-1:0] fill_cnt,
    input logic             wr_en,
    input logic [CAP_W-1:0] wr_addr,
    input logic [CAP_W-1:0] cap_q,
    input logic             doorbell,
    input logic             done,
    input logic             error
);
    // R2
    pop_needs_fill_chk: assert property (@(posedge clk) disable iff (rst)
        slot_pop |-> (fill_cnt != '0));

    // R8
    doorbell_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        doorbell |=> !doorbell);

    // R3
    no_write_past_cap_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr < cap_q));

    // R9
    err_implies_done_chk: assert property (@(posedge clk) disable iff (rst)
        error |-> done);

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
endmodule

bind msg_reassembler rxm_checker #(.CAP_W(CAP_W), .CNT_W(CNT_W)) u_rxm_chk (
    .clk(clk), .rst(rst), .start(start), .slot_pop(slot_pop),
    .fill_cnt(fill_cnt), .wr_en(wr_en), .wr_addr(wr_addr), .cap_q(cap_q),
    .doorbell(doorbell), .done(done), .error(error)
);

// File: tb/test_msg_reassembler.sv
`timescale 1ns/100ps
module test_msg_reassembler;
    localparam int CAP_W   = 10;
    localparam int CNT_W   = 8;
    localparam int TIMEOUT = 16;
    localparam int RETRIES = 5;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, peer_ready = 1'b1;
    logic [CAP_W-1:0] capacity = CAP_W'(64);
    logic [CNT_W-1:0] fill_cnt = '0;
    logic [31:0] slot_data = '0;
    logic slot_pop, wr_en, doorbell, done, error;
    logic [CAP_W-1:0] wr_addr, rx_len;
    logic [7:0] wr_data;

    always #2.5 clk = ~clk;

    msg_reassembler #(.CAP_W(CAP_W), .CNT_W(CNT_W), .TIMEOUT(TIMEOUT), .RETRIES(RETRIES)) i_msg_reassembler (
        .clk(clk), .rst(rst), .start(start), .capacity(capacity), .fill_cnt(fill_cnt),
        .slot_data(slot_data), .peer_ready(peer_ready), .slot_pop(slot_pop), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .doorbell(doorbell), .rx_len(rx_len),
        .done(done), .error(error));

    int checks = 0, errors = 0, cyc = 0, wr_cnt = 0, bell_cnt = 0, exp_addr = 0;
    logic [31:0] mbox[$];
    logic [31:0] pend[$];
    logic [CAP_W+7:0] exp_q[$];
    logic pop_q = 1'b0, flush_req = 1'b0;

    // mailbox model: pops registered at the edge, applied at the falling edge
    always @(posedge clk) pop_q <= slot_pop;
    always @(negedge clk) begin
        if (flush_req) begin
            mbox.delete();
            pend.delete();
            flush_req = 1'b0;
        end else if (pop_q && mbox.size() > 0) begin
            void'(mbox.pop_front());
        end
        while (pend.size() > 0) mbox.push_back(pend.pop_front());
        fill_cnt  = CNT_W'(mbox.size());
        slot_data = (mbox.size() > 0) ? mbox[0] : 32'h0;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: scoreboard compare of the byte port
    always @(negedge clk) begin
        if (!rst) begin
            if (doorbell) bell_cnt++;
            if (wr_en) begin
                wr_cnt++;
                if (exp_q.size() == 0) begin
                    check(0, "R5 unexpected byte write addr", int'(wr_addr), -1);
                end else begin
                    logic [CAP_W+7:0] e;
                    e = exp_q.pop_front();
                    check({wr_addr, wr_data} == e, "R5/R6 byte addr+data",
                          int'({wr_addr, wr_data}), int'(e));
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // driver: header bits 30:25 zero, low half is junk; tail upper bytes are 0xEE
    task automatic push_frag(input int len, input bit fin, input int seed, input bit expect_wr);
        logic [31:0] w;
        pend.push_back({fin, 6'd0, 9'(len), 16'hA55A});
        for (int i = 0; i < len; i += 4) begin
            w = 32'hEEEE_EEEE;
            for (int b = 0; b < 4; b++) begin
                if (i + b < len) begin
                    w[8*b +: 8] = 8'(seed + i + b);
                    if (expect_wr) begin
                        exp_q.push_back({CAP_W'(exp_addr), 8'(seed + i + b)});
                        exp_addr++;
                    end
                end
            end
            pend.push_back(w);
        end
    endtask

    task automatic flush();
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
        exp_q.delete();
    endtask

    task automatic kick(input int cap);
        @(negedge clk);
        capacity = CAP_W'(cap);
        wr_cnt = 0; bell_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_msg(input string tag, input bit exp_err, input int exp_len,
                              input int exp_bell, input int exp_wr);
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, {tag, " done"}, int'(done), 1);
        check(error == exp_err, {tag, " error"}, int'(error), int'(exp_err));
        check(int'(rx_len) == exp_len, {tag, " rx_len"}, int'(rx_len), exp_len);
        check(bell_cnt == exp_bell, {tag, " doorbell count"}, bell_cnt, exp_bell);
        check(wr_cnt == exp_wr, {tag, " byte writes"}, wr_cnt, exp_wr);
        check(exp_q.size() == 0, {tag, " missing bytes"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!done && !error && !slot_pop && !wr_en && !doorbell && rx_len == '0,
              "R1 reset outputs", int'({done, error, slot_pop, wr_en, doorbell}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2 R5 R6 R9: single final fragment, 6 bytes (one word plus a 2-byte tail)
        exp_addr = 0;
        push_frag(6, 1, 8'h10, 1);
        kick(64);
        finish_msg("R6 single frag len6", 0, 6, 0, 6);

        // R8: non-final fragment drains mailbox, doorbell requests the rest
        flush(); exp_addr = 0;
        push_frag(4, 0, 8'h20, 1);
        kick(64);
        begin
            int n = 0;
            while (bell_cnt == 0 && n < 500) begin @(negedge clk); n++; end
        end
        check(bell_cnt == 1, "R8 doorbell after drained non-final", bell_cnt, 1);
        push_frag(3, 1, 8'h30, 1);
        finish_msg("R8 two frags", 0, 7, 1, 7);

        // R8 R5: both fragments already queued, no doorbell, addresses continue
        flush(); exp_addr = 0;
        push_frag(5, 0, 8'h40, 1);
        push_frag(8, 1, 8'h50, 1);
        kick(64);
        finish_msg("R8 preloaded no bell", 0, 13, 0, 13);

        // R4: payload not taken until all its slots are present
        flush(); exp_addr = 0;
        begin
            logic [31:0] w2;
            push_frag(8, 1, 8'h60, 1);
            w2 = pend.pop_back();
            kick(64);
            repeat (12) @(negedge clk);
            check(wr_cnt == 0, "R4 no payload before slots filled", wr_cnt, 0);
            pend.push_back(w2);
        end
        finish_msg("R4 late payload", 0, 8, 0, 8);

        // R3: oversize fragment
        flush(); exp_addr = 0;
        push_frag(5, 1, 8'h70, 0);
        kick(4);
        finish_msg("R3 oversize", 1, 0, 0, 0);

        // R11: capacity used up by a non-final fragment
        flush(); exp_addr = 0;
        push_frag(4, 0, 8'h80, 1);
        kick(4);
        finish_msg("R11 capacity exhausted", 1, 4, 0, 4);

        // R10: zero-length final fragment alone, then after data
        flush(); exp_addr = 0;
        push_frag(0, 1, 0, 1);
        kick(64);
        finish_msg("R10 zero-length only", 0, 0, 0, 0);
        flush(); exp_addr = 0;
        push_frag(3, 0, 8'h90, 1);
        push_frag(0, 1, 0, 1);
        kick(64);
        finish_msg("R10 zero-length final after data", 0, 3, 0, 3);

        // R7: peer drops ready during the whole words
        flush(); exp_addr = 0;
        push_frag(8, 1, 8'hA0, 1);
        kick(64);
        begin
            int n = 0;
            while (!wr_en && n < 500) begin @(negedge clk); n++; end
        end
        peer_ready = 1'b0;
        finish_msg("R7 peer lost", 1, 8, 0, 8);
        peer_ready = 1'b1;

        // R12: peer never ready -> error after all windows
        flush(); exp_addr = 0;
        peer_ready = 1'b0;
        begin
            int n = 0;
            kick(64);
            while (!done && n < 3000) begin @(negedge clk); n++; end
            check(n + 1 >= TIMEOUT * RETRIES, "R12 waited all windows", n + 1, TIMEOUT * RETRIES);
        end
        finish_msg("R12 give up", 1, 0, 0, 0);

        // R12: ready arrives in the third window
        flush(); exp_addr = 0;
        push_frag(2, 1, 8'hB0, 1);
        kick(64);
        repeat (2 * TIMEOUT + 8) @(negedge clk);
        check(done == 1'b0, "R12 still waiting", int'(done), 0);
        peer_ready = 1'b1;
        finish_msg("R12 late ready", 0, 2, 0, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule